// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Unit

This block gathers the receive-done and transmit-done pulses of a fast Ethernet MAC and turns them into one level interrupt. Each direction passes through its own moderation channel. A channel reports an event only after a programmed number of packets has arrived, or after a programmed number of prescaled ticks has elapsed while at least one packet is still unreported. When a channel reports, it sets a bit in a 16-bit pending register. The interrupt line is the registered OR of the pending bits that a 16-bit enable register lets through.

Software uses a word-wide register port. A read returns the pending bits and clears them in the same access. A single write to the enable register either silences the line or re-arms it. Each moderation word holds two fields. The high byte is the timeout in ticks, and the low byte is the packet threshold. One tick lasts `TICK_DIV` clock cycles and comes from a free-running prescaler that starts counting at reset release.

Each moderation channel is a two-state machine:
- `MOD_IDLE`: no packet is outstanding.
- `MOD_ACCUM`: at least one packet is outstanding, and the packet count and tick count are advancing.

Transitions:
- `MOD_IDLE -> MOD_ACCUM`: a packet arrives that does not reach the threshold.
- `MOD_IDLE -> MOD_IDLE`: a packet reaches the threshold on its own (threshold 0 or 1). The channel reports and stays idle.
- `MOD_ACCUM -> MOD_IDLE`: the threshold or the timeout is reached. The channel reports, and both counters restart from zero.
- `MOD_ACCUM -> MOD_ACCUM`: all other cycles.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, every register reads 0x0000 and `irq_o` is low.
- R2: Register byte offsets:
  - 0x0C is the receive moderation word. Bits 15:8 hold the timeout and bits 7:0 hold the threshold.
  - 0x10 is the transmit moderation word, with the same layout.
  - 0x40 is the enable (mask) register.
  - These three read back the value written.
  - 0x3C is the pending register. Bit 0 is receive and bit 4 is transmit. All its other bits read 0, and writes to it are ignored.
  - All other offsets read 0x0000.
- R3: A read of offset 0x3C returns the pending bits, and the bits read are 0 from the next cycle on.
- R4: An event reported in the same cycle as a pending-register read returns 0 in that read and is still pending afterwards.
- R5: `irq_o` in a cycle equals the OR of (pending AND enable) as held in the previous cycle.
- R6: An enable value of 0x0000 keeps `irq_o` low whatever is pending. Writing 0x0011 enables both sources and raises the line for bits that are already pending.
- R7: With a threshold field of 0 or 1, every packet is reported on the clock edge that samples its pulse.
- R8: With a threshold T > 1 and the timeout field 0, the T-th packet is reported and the earlier ones are not.
- R9: With a timeout N > 0, a channel holding unreported packets reports at the N-th tick after its first outstanding packet, unless the threshold is reached first.
- R10: A channel with no outstanding packet never reports on a timeout.
- R11: The two directions count, time and report independently.
- R12: After a report, the channel's packet and tick counts start again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done_i | input | 1 | One-cycle receive-complete pulse |
| tx_done_i | input | 1 | One-cycle transmit-complete pulse |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears pending on 0x3C) |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational from the offset |
| irq_o | output | 1 | Registered level interrupt |

## Verification
A channel stuck in `MOD_ACCUM` or holding a wrong count shows up as a pending bit that appears a packet early or late. It also shows up as a timeout that fires one tick off, or fires with nothing outstanding. The bench catches either case on the first cycle that the pending register or `irq_o` differs from the behavioural model. A wrong clear-on-read or a lost coincident event shows in the next read of offset 0x3C, and in `irq_o` one cycle after the register changes.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int OFS_RXMOD  = 'h0C;
    localparam int OFS_TXMOD  = 'h10;
    localparam int OFS_STATUS = 'h3C;
    localparam int OFS_MASK   = 'h40;
    localparam int RX_BIT     = 0;
    localparam int TX_BIT     = 4;
    localparam int NUM_DIR    = 2;

    typedef enum logic {
        MOD_IDLE  = 1'b0,
        MOD_ACCUM = 1'b1
    } mod_state_e;
endpackage

// File: rtl/isr_prescale.sv
module isr_prescale #(
    parameter int TICK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/isr_mod_chan.sv
module isr_mod_chan
    import isr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] thr_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             fire_o,
    output logic             idle_o
);
    mod_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [TMO_W-1:0] tmr_q, tmr_d;
    logic [CNT_W:0]   cnt_inc;
    logic [TMO_W:0]   tmr_inc;
    logic             evt_hit, tmo_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MOD_IDLE;
            cnt_q   <= '0;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tmr_q   <= tmr_d;
        end
    end

    // outputs: report conditions
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        tmr_inc = {1'b0, tmr_q} + 1'b1;
        evt_hit = evt_i && (cnt_inc >= {1'b0, thr_i});
        tmo_hit = (state_q == MOD_ACCUM) && tick_i && (tmo_i != '0)
                  && (tmr_inc >= {1'b0, tmo_i});
        fire_o  = evt_hit || tmo_hit;
        idle_o  = (state_q == MOD_IDLE);
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tmr_d   = tmr_q;
        unique case (state_q)
            MOD_IDLE: begin
                if (evt_i && !fire_o) begin
                    state_d = MOD_ACCUM;
                    cnt_d   = CNT_W'(1);
                    tmr_d   = '0;
                end
            end
            MOD_ACCUM: begin
                if (fire_o) begin
                    state_d = MOD_IDLE;
                    cnt_d   = '0;
                    tmr_d   = '0;
                end else begin
                    if (evt_i)                   cnt_d = cnt_inc[CNT_W-1:0];
                    if (tick_i && (tmr_q != '1)) tmr_d = tmr_inc[TMO_W-1:0];
                end
            end
            default: state_d = MOD_IDLE;
        endcase
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import isr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int TICK_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done_i,
    input  logic              tx_done_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam int HALF = DATA_W / 2;
    localparam logic [ADDR_W-1:0] A_RXMOD  = ADDR_W'(OFS_RXMOD);
    localparam logic [ADDR_W-1:0] A_TXMOD  = ADDR_W'(OFS_TXMOD);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);

    logic [DATA_W-1:0]  mod_q [NUM_DIR];
    logic [DATA_W-1:0]  mask_q, status_q, set_vec;
    logic [NUM_DIR-1:0] evt, fire, chan_idle;
    logic               tick, rd_status, irq_q;

    assign evt = {tx_done_i, rx_done_i};

    isr_prescale #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        isr_mod_chan #(.CNT_W(HALF), .TMO_W(DATA_W - HALF)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt[d]),
            .tick_i(tick),
            .thr_i (mod_q[d][HALF-1:0]),
            .tmo_i (mod_q[d][DATA_W-1:HALF]),
            .fire_o(fire[d]),
            .idle_o(chan_idle[d])
        );
    end

    always_comb begin
        set_vec         = '0;
        set_vec[RX_BIT] = fire[0];
        set_vec[TX_BIT] = fire[1];
    end

    assign rd_status = reg_rd_i && (reg_addr_i == A_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
            irq_q    <= 1'b0;
            for (int d = 0; d < NUM_DIR; d++) mod_q[d] <= '0;
        end else begin
            status_q <= (status_q & ~{DATA_W{rd_status}}) | set_vec;
            irq_q    <= |(status_q & mask_q);
            if (reg_wr_i) begin
                if (reg_addr_i == A_RXMOD) mod_q[0] <= reg_wdata_i;
                if (reg_addr_i == A_TXMOD) mod_q[1] <= reg_wdata_i;
                if (reg_addr_i == A_MASK)  mask_q   <= reg_wdata_i;
            end
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == A_RXMOD)  reg_rdata_o = mod_q[0];
        if (reg_addr_i == A_TXMOD)  reg_rdata_o = mod_q[1];
        if (reg_addr_i == A_STATUS) reg_rdata_o = status_q;
        if (reg_addr_i == A_MASK)   reg_rdata_o = mask_q;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/isr_chk.sv
module isr_chk
    import isr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              tx_done_i,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] mask_q,
    input logic [1:0]        fire,
    input logic [1:0]        chan_idle,
    input logic              irq_o
);
    // R3
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == ADDR_W'(OFS_STATUS) && !fire[0])
        |=> !status_q[RX_BIT]);

    // R4
    evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire[1] |=> status_q[TX_BIT]);

    // R6
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq_o);

    // R5
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[RX_BIT] && mask_q[RX_BIT]) |=> irq_o);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_idle[1] && !tx_done_i) |-> !fire[1]);
endmodule

bind irq_status_unit isr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_isr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd_i  (reg_rd_i),
    .reg_addr_i(reg_addr_i),
    .tx_done_i (tx_done_i),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .fire      (fire),
    .chan_idle (chan_idle),
    .irq_o     (irq_o)
);

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_done = 1'b0, tx_done = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        irq;

    int total = 0, bad = 0, cyc = 0;
    bit done = 1'b0;

    irq_status_unit #(.TICK_DIV(DIV)) i_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done), .tx_done_i(tx_done),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    int m_pc = 0, m_status = 0, m_mask = 0, m_irq = 0;
    int m_mod [2] = '{0, 0};
    int m_cnt [2] = '{0, 0};
    int m_el  [2] = '{0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_status = 0; m_mask = 0; m_irq = 0;
            for (int d = 0; d < 2; d++) begin m_mod[d] = 0; m_cnt[d] = 0; m_el[d] = 0; end
        end else begin
            bit tk;
            int fb, nirq;
            fb = 0;
            tk = (m_pc == DIV - 1);
            m_pc = tk ? 0 : m_pc + 1;
            for (int d = 0; d < 2; d++) begin
                bit ev, f;
                int thr, tmo;
                ev  = (d == 0) ? rx_done : tx_done;
                thr = m_mod[d] & 255;
                tmo = (m_mod[d] >> 8) & 255;
                f = (ev && (m_cnt[d] + 1 >= thr)) ||
                    (m_cnt[d] > 0 && tk && tmo != 0 && m_el[d] + 1 >= tmo);
                if (f) begin
                    m_cnt[d] = 0; m_el[d] = 0;
                    fb = fb | ((d == 0) ? 1 : 16);
                end else begin
                    if (m_cnt[d] > 0 && tk && m_el[d] < 255) m_el[d]++;
                    if (ev) m_cnt[d]++;
                end
            end
            nirq = ((m_status & m_mask) != 0) ? 1 : 0;
            if (rd && addr == 8'h3C) m_status = 0;
            m_status = m_status | fb;
            if (wr) begin
                if (addr == 8'h0C) m_mod[0] = wdata;
                if (addr == 8'h10) m_mod[1] = wdata;
                if (addr == 8'h40) m_mask = wdata;
            end
            m_irq = nirq;
        end
    end

    function automatic int m_read(input logic [7:0] a);
        case (a)
            8'h0C:   return m_mod[0];
            8'h10:   return m_mod[1];
            8'h3C:   return m_status;
            8'h40:   return m_mask;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R5 irq model", int'(irq), m_irq);
            chk("R2 rdata model", int'(rdata), m_read(addr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] v);
        @(negedge clk); addr = a; wdata = v; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output int v);
        @(negedge clk); addr = a; rd = 1'b1;
        #3 v = rdata;
        @(negedge clk); rd = 1'b0; addr = 8'h00;
    endtask

    task automatic pulse(input bit is_tx);
        @(negedge clk);
        if (is_tx) tx_done = 1'b1; else rx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0; rx_done = 1'b0;
    endtask

    int v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #3 chk("R1 irq", int'(irq), 0);
        rd_reg(8'h0C, v); chk("R1 rxmod", v, 0);
        rd_reg(8'h10, v); chk("R1 txmod", v, 0);
        rd_reg(8'h3C, v); chk("R1 status", v, 0);
        rd_reg(8'h40, v); chk("R1 mask", v, 0);

        // R2 map and readback
        wr_reg(8'h0C, 16'h1234); rd_reg(8'h0C, v); chk("R2 rxmod", v, 16'h1234);
        wr_reg(8'h10, 16'hABCD); rd_reg(8'h10, v); chk("R2 txmod", v, 16'hABCD);
        wr_reg(8'h40, 16'h0011); rd_reg(8'h40, v); chk("R2 mask", v, 16'h0011);
        wr_reg(8'h3C, 16'hFFFF); rd_reg(8'h3C, v); chk("R2 status write ignored", v, 0);
        rd_reg(8'h20, v); chk("R2 unmapped", v, 0);
        wr_reg(8'h0C, 16'h0000); wr_reg(8'h10, 16'h0000);

        // R7 every packet, R5 irq, R3 clear on read
        pulse(0);
        #3 chk("R7 irq lags one cycle", int'(irq), 0);
        idle_cyc(1); #3 chk("R5 irq raised", int'(irq), 1);
        rd_reg(8'h3C, v); chk("R7 rx reported", v, 16'h0001);
        rd_reg(8'h3C, v); chk("R3 cleared", v, 0);
        idle_cyc(1); #3 chk("R5 irq dropped", int'(irq), 0);

        // R4 event coincides with read
        @(negedge clk); addr = 8'h3C; rd = 1'b1; tx_done = 1'b1;
        #3 v = rdata; chk("R4 read during event", v, 0);
        @(negedge clk); rd = 1'b0; tx_done = 1'b0;
        rd_reg(8'h3C, v); chk("R4 event kept", v, 16'h0010);

        // R6 mask
        wr_reg(8'h40, 16'h0000);
        pulse(1); idle_cyc(4);
        #3 chk("R6 masked irq low", int'(irq), 0);
        wr_reg(8'h40, 16'h0011);
        idle_cyc(1); #3 chk("R6 re-armed irq", int'(irq), 1);
        rd_reg(8'h3C, v); chk("R6 pending tx", v, 16'h0010);

        // R8 threshold 3
        wr_reg(8'h0C, 16'h0003);
        pulse(0); pulse(0); idle_cyc(2);
        rd_reg(8'h3C, v); chk("R8 before threshold", v, 0);
        pulse(0);
        rd_reg(8'h3C, v); chk("R8 third packet", v, 16'h0001);

        // R12 restart after report
        pulse(0); pulse(0);
        rd_reg(8'h3C, v); chk("R12 count restarted", v, 0);
        pulse(0);
        rd_reg(8'h3C, v); chk("R12 fires again", v, 16'h0001);

        // R9 timeout 8 ticks, threshold 2
        wr_reg(8'h0C, 16'h0802);
        pulse(0); idle_cyc(20);
        rd_reg(8'h3C, v); chk("R9 before timeout", v, 0);
        idle_cyc(60);
        rd_reg(8'h3C, v); chk("R9 timeout report", v, 16'h0001);

        // R10 no outstanding packet
        wr_reg(8'h10, 16'h0102);
        idle_cyc(100);
        rd_reg(8'h3C, v); chk("R10 no spurious timeout", v, 0);

        // R11 independent directions
        wr_reg(8'h0C, 16'h0000); wr_reg(8'h10, 16'h0002);
        pulse(1); pulse(0);
        rd_reg(8'h3C, v); chk("R11 rx alone", v, 16'h0001);
        pulse(1);
        rd_reg(8'h3C, v); chk("R11 tx second", v, 16'h0010);

        idle_cyc(3);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule